// File: doc/BRIEF.md
# Connection Memory with Handshake Processor Port

This block holds the per-timeslot control words of a timeslot interchange switch in a memory of 2^ADDR_W words, 16 bits wide by default. Two clients share it. The switching side reads the words in sequence, addressed by a free-running slot counter that an active-low frame pulse clears. A processor reads and writes single words through an asynchronous strobe-and-acknowledge port.

Each timeslot lasts two clock cycles. In the first half the sequential read-out reads the memory. The second half is kept for a processor access, so the two clients never collide.

The processor's select, strobe and direction lines pass through a synchroniser before they are used. The access runs in the next processor half-slot. An active-low acknowledge confirms the access and stays low until the processor lets go of the strobe. On a read, a drive enable tells the outside tri-state buffer when to put read data on the shared bus.

Top module: `cmem_uport`

## Requirements
- R1: After reset, ack_n is 1, rd_drive is 0, rd_data is 0 and sw_slot is 0.
- R2: With cs_n low, ds_n low and rw low (0 = write), the word on wr_data is stored at address addr. A later read of that address returns the stored word.
- R3: With cs_n low, ds_n low and rw high (1 = read), rd_drive is 1 while ack_n is 0, and rd_data holds the stored word at addr.
- R4: ack_n falls no later than four clock edges after ds_n falls, provided cs_n is low.
- R5: ack_n stays low for as long as ds_n and cs_n stay low. It returns to 1 no later than three edges after ds_n rises, and rd_drive falls with it.
- R6: A strobe while cs_n is high gives no acknowledge and leaves the memory contents unchanged.
- R7: sw_slot is 0 after the edge that follows the clock edge sampling frame_n low. It then advances by one every two cycles, so slot k is shown after edge 2k+1, and it wraps from 2^ADDR_W-1 to 0.
- R8: At each sw_slot update, sw_word equals the memory word at sw_slot, including words written by the processor.
- R9: rd_drive is never 1 during a write acknowledge. Each strobe gives exactly one access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame pulse; synchronously clears the slot counter |
| cs_n | input | 1 | Active-low processor select (asynchronous) |
| ds_n | input | 1 | Active-low processor strobe (asynchronous) |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Processor word address |
| wr_data | input | DATA_W | Processor write data |
| rd_data | output | DATA_W | Processor read data, zero when not driven |
| rd_drive | output | 1 | Enable for the external bus driver during a read acknowledge |
| ack_n | output | 1 | Active-low transfer acknowledge (1 models released) |
| sw_word | output | DATA_W | Control word for the current switching slot |
| sw_slot | output | ADDR_W | Slot address that sw_word was read from |

## Verification
A wrong phase or counter state shows on sw_slot within two cycles, because every update must be exactly one greater than the last and sit on the odd edges after the frame pulse. Memory corruption or a write landing at the wrong address shows as a sw_word mismatch within one frame, once the counter reaches that slot. It shows earlier if the processor reads the word back. A stuck or early handshake state shows through the acknowledge latency bounds and the hold checks within a few cycles of the strobe edge.

// File: rtl/cmem_pkg.sv
package cmem_pkg;
   typedef enum logic {
      PS_IDLE = 1'b0,
      PS_HOLD = 1'b1
   } port_st_t;
endpackage

// File: rtl/cmem_sync.sv
module cmem_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain[s] <= RST_VAL;
            else if (s == 0)
               chain[s] <= d;
            else
               chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cmem_seq.sv
module cmem_seq #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   output logic              proc_half,
   output logic [ADDR_W-1:0] slot_cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         proc_half <= 1'b0;
         slot_cnt  <= '0;
      end else if (!frame_n) begin
         proc_half <= 1'b0;
         slot_cnt  <= '0;
      end else begin
         proc_half <= ~proc_half;
         if (proc_half)
            slot_cnt <= slot_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/cmem_arb.sv
module cmem_arb
   import cmem_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sel_s,
   input  logic strobe_s,
   input  logic read_s,
   input  logic proc_half,
   output logic acc_we,
   output logic acc_re,
   output logic ack_n,
   output logic drive
);
   port_st_t st;
   logic     rd_q;
   logic     req;
   logic     go;

   assign req    = sel_s & strobe_s;
   assign go     = (st == PS_IDLE) & req & proc_half;
   assign acc_we = go & ~read_s;
   assign acc_re = go & read_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= PS_IDLE;
         rd_q <= 1'b0;
      end else begin
         case (st)
            PS_IDLE: if (go) begin
               st   <= PS_HOLD;
               rd_q <= read_s;
            end
            PS_HOLD: if (!req) begin
               st   <= PS_IDLE;
               rd_q <= 1'b0;
            end
            default: st <= PS_IDLE;
         endcase
      end
   end

   assign ack_n = (st != PS_HOLD);
   assign drive = (st == PS_HOLD) & rd_q;
endmodule

// File: rtl/cmem_store.sv
module cmem_store #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              proc_half,
   input  logic [ADDR_W-1:0] slot_cnt,
   input  logic              acc_we,
   input  logic              acc_re,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic [DATA_W-1:0] sw_word,
   output logic [ADDR_W-1:0] sw_slot
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (acc_we)
         mem[acc_addr] <= acc_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_rdata <= '0;
         sw_word   <= '0;
         sw_slot   <= '0;
      end else begin
         if (!proc_half) begin
            sw_word <= mem[slot_cnt];
            sw_slot <= slot_cnt;
         end
         if (acc_re)
            acc_rdata <= mem[acc_addr];
      end
   end
endmodule

// File: rtl/cmem_uport.sv
module cmem_uport #(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic              cs_n,
   input  logic              ds_n,
   input  logic              rw,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_drive,
   output logic              ack_n,
   output logic [ADDR_W-1:0] sw_slot,
   output logic [DATA_W-1:0] sw_word
);
   localparam int CTRL_W = 3;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cmem_uport: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("cmem_uport: widths must be positive");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
   logic              proc_half;
   logic [ADDR_W-1:0] slot_cnt;
   logic              acc_we, acc_re;
   logic [DATA_W-1:0] acc_rdata;

   assign ctrl_raw = {~cs_n, ~ds_n, rw};

   cmem_sync #(
      .WIDTH  (CTRL_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL('0)
   ) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (ctrl_raw),
      .q    (ctrl_s)
   );

   cmem_seq #(.ADDR_W(ADDR_W)) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_n  (frame_n),
      .proc_half(proc_half),
      .slot_cnt (slot_cnt)
   );

   cmem_arb i_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_s    (ctrl_s[2]),
      .strobe_s (ctrl_s[1]),
      .read_s   (ctrl_s[0]),
      .proc_half(proc_half),
      .acc_we   (acc_we),
      .acc_re   (acc_re),
      .ack_n    (ack_n),
      .drive    (rd_drive)
   );

   cmem_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .proc_half(proc_half),
      .slot_cnt (slot_cnt),
      .acc_we   (acc_we),
      .acc_re   (acc_re),
      .acc_addr (addr),
      .acc_wdata(wr_data),
      .acc_rdata(acc_rdata),
      .sw_word  (sw_word),
      .sw_slot  (sw_slot)
   );

   assign rd_data = rd_drive ? acc_rdata : '0;
endmodule

// File: rtl/cmem_uport_chk.sv
module cmem_uport_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_n,
   input logic              cs_n,
   input logic              ds_n,
   input logic              rw,
   input logic              rd_drive,
   input logic              ack_n,
   input logic [ADDR_W-1:0] sw_slot,
   input logic [DATA_W-1:0] rd_data
);
   // R6
   ack_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_n) |-> ($past(cs_n, 3) == 1'b0) && ($past(ds_n, 3) == 1'b0));

   // R5
   ack_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_n) |-> ($past(ds_n, 3) == 1'b1) || ($past(cs_n, 3) == 1'b1));

   // R9
   drive_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_drive |-> !ack_n);

   // R3
   drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_drive) |-> $fell(ack_n) && $past(rw, 3));

   // R7
   slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_slot != $past(sw_slot)) |-> (sw_slot == $past(sw_slot) + 1'b1) || (sw_slot == '0));

   // R1
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_drive |-> (rd_data == '0));

   // R7
   frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(frame_n) && frame_n) |=> (sw_slot == '0));
endmodule

bind cmem_uport cmem_uport_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .frame_n (frame_n),
   .cs_n    (cs_n),
   .ds_n    (ds_n),
   .rw      (rw),
   .rd_drive(rd_drive),
   .ack_n   (ack_n),
   .sw_slot (sw_slot),
   .rd_data (rd_data)
);

// File: tb/test_cmem_uport.sv
module test_cmem_uport;
   localparam int DW    = 16;
   localparam int AW    = 11;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_n = 1'b1;
   logic          cs_n = 1'b1;
   logic          ds_n = 1'b1;
   logic          rw = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          rd_drive;
   logic          ack_n;
   logic [AW-1:0] sw_slot;
   logic [DW-1:0] sw_word;

   int tests = 0;
   int fails = 0;
   logic [DW-1:0] model [DEPTH];
   bit            known [DEPTH];
   bit            pend = 1'b0;
   logic [AW-1:0] pend_addr = '0;
   bit            started = 1'b0;
   int            fc = 0;
   bit            done = 1'b0;

   always #2 clk = ~clk;

   cmem_uport #(.DATA_W(DW), .ADDR_W(AW)) i_cmem_uport (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .cs_n(cs_n), .ds_n(ds_n),
      .rw(rw), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
      .rd_drive(rd_drive), .ack_n(ack_n), .sw_slot(sw_slot), .sw_word(sw_word)
   );

   function automatic logic [AW-1:0] exp_slot(input int c);
      return AW'(((c - 1) >> 1) % DEPTH);
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!frame_n) begin
         fc <= 0;
         started <= 1'b1;
      end else begin
         fc <= fc + 1;
      end
   end

   // R7 and R8 monitor
   always @(negedge clk) begin
      if (rst_n && started && fc >= 1 && frame_n) begin
         check(sw_slot == exp_slot(fc), "R7 slot", 32'(sw_slot), 32'(exp_slot(fc)));
         if ((fc % 2) == 1 && known[sw_slot] && !(pend && pend_addr == sw_slot))
            check(sw_word == model[sw_slot], "R8 word", 32'(sw_word), 32'(model[sw_slot]));
      end
   end

   task automatic access(input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int n;
      @(negedge clk);
      addr = a; wr_data = d; rw = rd; cs_n = 1'b0;
      if (!rd) begin pend = 1'b1; pend_addr = a; end
      @(negedge clk);
      ds_n = 1'b0;
      n = 0;
      while (ack_n && n < 8) begin @(negedge clk); n++; end
      check(!ack_n && n <= 4, "R4 ack latency", 32'(n), 32'd4);
      if (rd) begin
         check(rd_drive == 1'b1, "R3 drive", 32'(rd_drive), 32'd1);
         if (known[a]) check(rd_data == model[a], "R3 data", 32'(rd_data), 32'(model[a]));
      end else begin
         check(rd_drive == 1'b0, "R9 no drive on write", 32'(rd_drive), 32'd0);
         model[a] = d; known[a] = 1'b1;
      end
      repeat (2) @(negedge clk);
      check(ack_n == 1'b0, "R5 hold", 32'(ack_n), 32'd0);
      ds_n = 1'b1; cs_n = 1'b1;
      n = 0;
      while (!ack_n && n < 8) begin @(negedge clk); n++; end
      check(ack_n && n <= 3, "R5 release", 32'(n), 32'd3);
      check(rd_drive == 1'b0, "R5 drive off", 32'(rd_drive), 32'd0);
      @(negedge clk);
      pend = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=expired expected=done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(ack_n == 1'b1, "R1 ack", 32'(ack_n), 32'd1);
      check(rd_drive == 1'b0, "R1 drive", 32'(rd_drive), 32'd0);
      check(rd_data == '0, "R1 data", 32'(rd_data), 32'd0);
      check(sw_slot == '0, "R1 slot", 32'(sw_slot), 32'd0);
      rst_n = 1'b1;
      @(negedge clk); frame_n = 1'b0;
      @(negedge clk); frame_n = 1'b1;

      // R2 directed, both ends of the address range
      access(1'b0, '0, 16'hA5C3);
      access(1'b0, AW'(DEPTH - 1), 16'h3C5A);
      access(1'b1, '0, '0);
      access(1'b1, AW'(DEPTH - 1), '0);
      check(known[0], "R2 written", 32'(known[0]), 32'd1);

      // R6 strobe without select
      begin
         int n;
         @(negedge clk);
         addr = '0; wr_data = 16'hFFFF; rw = 1'b0; cs_n = 1'b1;
         @(negedge clk); ds_n = 1'b0;
         n = 0;
         while (ack_n && n < 8) begin @(negedge clk); n++; end
         check(ack_n == 1'b1, "R6 no ack", 32'(ack_n), 32'd1);
         ds_n = 1'b1;
         repeat (3) @(negedge clk);
      end
      access(1'b1, '0, '0); // R6 memory unchanged (expects A5C3)

      // random traffic, R2 R3 R8 R9
      for (int k = 0; k < 300; k++) begin
         bit rd = $urandom_range(0, 1) == 1;
         logic [AW-1:0] a = AW'($urandom_range(0, 15) < 4 ? $urandom_range(0, 7) : $urandom_range(0, DEPTH - 1));
         access(rd, a, DW'($urandom));
      end

      // R7 frame pulse mid-run, then wrap through a full frame
      @(negedge clk); frame_n = 1'b0;
      @(negedge clk); frame_n = 1'b1;
      repeat (2 * DEPTH + 40) @(negedge clk);
      check(started && fc > 2 * DEPTH, "R7 wrap covered", 32'(fc), 32'(2 * DEPTH));

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule